// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Split Registers

This block is a byte-wide asynchronous serial port that sits on the peripheral bus of a small processor system. Software sees three word-aligned registers inside a 4 KB window. A store to the transmit register starts one serial frame with the low byte of the stored word. A load from the receive register hands back the oldest byte held in an eight-entry receive queue and removes that byte. A load from the status register shows whether the transmitter is still shifting and whether a received byte is waiting.

The serial format is fixed: one start bit, eight data bits least significant bit first, no parity, and one stop bit. The bit period in clock cycles is derived from two parameters, the clock frequency and the baud rate. With the defaults of 50 MHz and 115200 baud this gives 434 cycles per bit. The receive line passes through a two-flop synchronizer. The receiver confirms a start bit at its midpoint and samples every later bit at mid-bit. Every bus access is acknowledged exactly one cycle after it is presented, so its latency is fixed.

Top module: `mmio_uart`

## Requirements
- R1: For every access, mapped or not, `ready_o` is high in the cycle after the first cycle in which `valid_i` is high and `ready_o` is low, and it stays high for only that one cycle.
- R2: A write to offset 0x000 while the transmitter is idle sends the low byte of `wdata_i` on `tx_o`. The frame is a low start bit, then data bits 0 to 7, then a high stop bit, and each bit lasts CLK_HZ/BAUD cycles. `tx_o` is high whenever no frame is in progress.
- R3: A read of offset 0x008 returns the transmitter-busy flag in bit 0 and the receive-data-available flag in bit 1. All other bits read as zero. Busy is set from the accepted write until the end of the stop bit.
- R4: A write to offset 0x000 while the transmitter is busy is ignored. The current frame completes unchanged and no further frame follows.
- R5: A read of offset 0x004 returns the oldest received byte in bits 7:0, with zeros above, and removes that byte. Bytes come out in the order they arrived.
- R6: A read of offset 0x004 while the receive queue is empty returns zero and leaves the queue and the status unchanged.
- R7: A low pulse on `rx_i` that is shorter than half a bit period is not taken as a start bit, and no byte is received.
- R8: The receive queue holds 8 bytes. A byte that completes while the queue is full is dropped, and the stored bytes are kept.
- R9: After reset, `tx_o` is high, `ready_o` is low and the status register reads zero.
- R10: Reads of unmapped or misaligned offsets, and of the transmit offset, return zero. Writes to any offset other than 0x000 have no effect on the line or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus access request |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset inside the register window |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Access acknowledge, one cycle after request |
| rdata_o | output | 32 | Read data, valid while ready_o is high |
| rx_i | input | 1 | Serial receive line, asynchronous |
| tx_o | output | 1 | Serial transmit line, idles high |

## Verification
The bench runs the block at eight cycles per bit. It sends all 256 byte values out through the transmitter and decodes each frame at mid-bit. This separates bit-order, shift and stop-bit faults from busy-flag timing faults. It also feeds all 256 values into the receiver and reads each one back, which exposes sampling-phase and data-path errors that a few chosen bytes could miss. Four targeted patterns follow. A burst of ten frames into an empty queue separates drop-on-full from overwrite. A sub-half-bit glitch separates midpoint start validation from plain edge detection. A second write during a frame checks that the second write is ignored. Stray offsets check that register decode is exact.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  // word index of each register inside the window (addr_i[11:2])
  localparam logic [9:0] IDX_TX   = 10'd0;
  localparam logic [9:0] IDX_RX   = 10'd1;
  localparam logic [9:0] IDX_STAT = 10'd2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx #(
  parameter int CPB = 434
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam int CW = (CPB > 1) ? $clog2(CPB) : 1;
  localparam logic [CW-1:0] LAST = CW'(CPB - 1);

  logic [9:0]    sh_q;
  logic [3:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        bit_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      if (bit_q == 4'd9) begin
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {1'b1, sh_q[9:1]};
        bit_q <= bit_q + 4'd1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int CPB = 434
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       push_o,
  output logic [7:0] data_o
);
  localparam int CW = (CPB > 1) ? $clog2(CPB) : 1;
  localparam logic [CW-1:0] LAST = CW'(CPB - 1);
  localparam logic [CW-1:0] HALF = CW'((CPB / 2 > 0) ? CPB / 2 - 1 : 0);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          push_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (!rx_s) begin
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: if (cnt_q == HALF) begin
          // start must still be low at its midpoint
          st_q  <= rx_s ? RX_IDLE : RX_DATA;
          cnt_q <= '0;
          bit_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        RX_DATA: if (cnt_q == LAST) begin
          cnt_q <= '0;
          sh_q  <= {rx_s, sh_q[7:1]};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) st_q <= RX_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        RX_STOP: if (cnt_q == LAST) begin
          st_q   <= RX_IDLE;
          push_q <= rx_s;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign push_o = push_q;
  assign data_o = sh_q;
endmodule

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
  parameter int DEPTH = 8,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [7:0]      data_i,
  input  logic            pop_i,
  output logic [7:0]      head_o,
  output logic            empty_o,
  output logic [CNTW-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [7:0]      mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_push, do_pop;

  assign do_push = push_i && (cnt_q != FULL_CNT);
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 115_200,
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        write_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic        ready_o,
  output logic [31:0] rdata_o,
  input  logic        rx_i,
  output logic        tx_o
);
  localparam int CPB  = CLK_HZ / BAUD;
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  logic            ready_q;
  logic [31:0]     rdata_q;
  logic            acc, aligned;
  logic            tx_busy, rx_push, rx_avail, fifo_empty;
  logic [7:0]      rx_byte, fifo_head;
  logic [CNTW-1:0] fifo_cnt;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i[31:8];
  assign acc      = valid_i && !ready_q;
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign rx_avail = !fifo_empty;

  mmio_uart_tx #(.CPB(CPB)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(acc && write_i && aligned && addr_i[11:2] == IDX_TX),
    .data_i (wdata_i[7:0]),
    .busy_o (tx_busy),
    .tx_o   (tx_o)
  );

  mmio_uart_rx #(.CPB(CPB)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .push_o(rx_push),
    .data_o(rx_byte)
  );

  mmio_uart_fifo #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_push),
    .data_i (rx_byte),
    .pop_i  (acc && !write_i && aligned && addr_i[11:2] == IDX_RX),
    .head_o (fifo_head),
    .empty_o(fifo_empty),
    .cnt_o  (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= acc;
      if (acc) begin
        rdata_q <= '0;
        if (!write_i && aligned) begin
          unique case (addr_i[11:2])
            IDX_RX:   rdata_q <= {24'd0, fifo_empty ? 8'd0 : fifo_head};
            IDX_STAT: rdata_q <= {30'd0, rx_avail, tx_busy};
            default:  rdata_q <= '0;
          endcase
        end
      end
    end
  end

  assign ready_o = ready_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk #(
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            write_i,
  input logic [11:0]     addr_i,
  input logic            ready_o,
  input logic [31:0]     rdata_o,
  input logic            tx_o,
  input logic            tx_busy,
  input logic [CNTW-1:0] fifo_cnt
);
  assert_ack_next_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_o) |=> ready_o);

  assert_ack_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_line_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> tx_o);

  assert_busy_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(valid_i && !ready_o && write_i && addr_i == 12'h000));

  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rdata_o[31:8] == 24'd0));

  assert_empty_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_o && !write_i && addr_i == 12'h004 && fifo_cnt == '0)
      |=> (rdata_o == 32'd0));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNTW'(DEPTH));
endmodule

bind mmio_uart mmio_uart_chk #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .write_i (write_i),
  .addr_i  (addr_i),
  .ready_o (ready_o),
  .rdata_o (rdata_o),
  .tx_o    (tx_o),
  .tx_busy (tx_busy),
  .fifo_cnt(fifo_cnt)
);

// File: tb/mmio_uart_tb.sv
`timescale 1ns/1ps
module mmio_uart_tb;
  localparam int CPB = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0, write = 1'b0, rx = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready_o, tx_o;
  logic [31:0] rdata_o;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mmio_uart #(.CLK_HZ(CPB * 100), .BAUD(100), .FIFO_DEPTH(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready_o), .rdata_o(rdata_o),
    .rx_i(rx), .tx_o(tx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                     output logic [31:0] rd);
    @(negedge clk); valid = 1'b1; write = wr; addr = a; wdata = wd;
    @(negedge clk); chk("R1 ready after valid", {31'd0, ready_o}, 32'd1);
    rd = rdata_o; valid = 1'b0;
    @(negedge clk); chk("R1 ready single cycle", {31'd0, ready_o}, 32'd0);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus(1'b0, a, 32'd0, d);
    chk(req, d, exp);
  endtask

  // decode one frame from tx_o at mid-bit
  task automatic capture(output logic [7:0] b);
    int guard = 0;
    b = '0;
    while (tx_o !== 1'b0 && guard < 300) begin @(negedge clk); guard++; end
    chk("R2 frame start seen", {31'd0, tx_o}, 32'd0);
    repeat (CPB / 2) @(negedge clk);
    chk("R2 start bit low", {31'd0, tx_o}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      b[i] = tx_o;
    end
    repeat (CPB) @(negedge clk);
    chk("R2 stop bit high", {31'd0, tx_o}, 32'd1);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx = 1'b0;
    repeat (CPB - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  got;
    logic [31:0] d;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 tx idle", {31'd0, tx_o}, 32'd1);
    chk("R9 ready low", {31'd0, ready_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd_chk(12'h008, 32'd0, "R9 status zero");
    // R6 empty read
    rd_chk(12'h004, 32'd0, "R6 empty read zero");
    rd_chk(12'h008, 32'd0, "R6 status unchanged");

    // R2/R3 exhaustive transmit sweep
    for (int v = 0; v < 256; v++) begin
      fork
        capture(got);
        bus(1'b1, 12'h000, {24'hFFFFFF, 8'(v)}, d);
      join
      chk("R2 tx byte", {24'd0, got}, 32'(v));
      rd_chk(12'h008, 32'h1, "R3 busy during stop");
      repeat (CPB + 2) @(negedge clk);
      rd_chk(12'h008, 32'h0, "R3 busy cleared");
    end

    // R4 write while busy ignored
    fork
      capture(got);
      begin
        bus(1'b1, 12'h000, 32'hA5, d);
        bus(1'b1, 12'h000, 32'h3C, d);
      end
    join
    chk("R4 first frame kept", {24'd0, got}, 32'hA5);
    repeat (CPB + 2) @(negedge clk);
    for (int i = 0; i < 3 * CPB; i++) begin
      @(negedge clk);
      if (tx_o !== 1'b1) chk("R4 no second frame", {31'd0, tx_o}, 32'd1);
    end
    rd_chk(12'h008, 32'h0, "R4 status idle");

    // R5 exhaustive receive sweep
    for (int v = 0; v < 256; v++) begin
      send(8'(v));
      @(negedge clk);
      rd_chk(12'h008, 32'h2, "R3 rx available");
      rd_chk(12'h004, 32'(v), "R5 rx byte");
      rd_chk(12'h008, 32'h0, "R5 popped");
    end

    // R8 overflow: ten frames into an eight-entry queue
    for (int v = 0; v < 10; v++) send(8'(8'h40 + v));
    @(negedge clk);
    for (int v = 0; v < 8; v++) rd_chk(12'h004, 32'(8'h40 + v), "R8 order kept when full");
    rd_chk(12'h004, 32'd0, "R8 extra bytes dropped");
    rd_chk(12'h008, 32'h0, "R8 queue drained");

    // R7 short glitch rejected
    @(negedge clk); rx = 1'b0;
    repeat (2) @(negedge clk); rx = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    rd_chk(12'h008, 32'h0, "R7 glitch no byte");
    rd_chk(12'h004, 32'h0, "R7 glitch empty read");

    // R10 stray offsets
    bus(1'b1, 12'h00C, 32'h55, d);
    bus(1'b1, 12'h008, 32'h55, d);
    bus(1'b1, 12'h004, 32'h55, d);
    bus(1'b1, 12'h001, 32'h55, d);
    for (int i = 0; i < 2 * CPB; i++) begin
      @(negedge clk);
      if (tx_o !== 1'b1) chk("R10 stray write no frame", {31'd0, tx_o}, 32'd1);
    end
    rd_chk(12'h008, 32'h0, "R10 status untouched");
    rd_chk(12'h000, 32'h0, "R10 tx offset reads zero");
    rd_chk(12'h00C, 32'h0, "R10 unmapped reads zero");
    send(8'h77);
    @(negedge clk);
    rd_chk(12'h00A, 32'h0, "R10 misaligned status zero");
    rd_chk(12'h005, 32'h0, "R10 misaligned rx no pop");
    rd_chk(12'h004, 32'h77, "R10 byte still queued");

    finish_run();
  end
endmodule